// File: doc/BRIEF.md
# Single-Channel Asynchronous Serial Transceiver

This block is one serial channel for a larger chip. Software drives it through a small register window over a plain read/write bus. Each access is either a byte or a halfword. The channel holds the following registers:

- a frame setup register;
- a 16-bit rate divider;
- a sticky status register;
- a receive register, readable as a plain byte or as a halfword that also carries per-character error flags;
- a transmit register that takes one byte.

The bit time is twice the divider value in core clocks. Divider values below 4 count as 4. A frame can carry 7 or 8 data bits, sent least- or most-significant first. Parity can be absent, forced to zero, odd or even. The transmitter sends one or two stop bits.

The transmitter has a single holding byte in front of its shift register. It raises a one-clock pulse at the end of every frame. The receiver works as follows:

- It synchronises the line and starts a frame on a low level.
- At mid-bit it checks the start bit again, which rejects short glitches.
- It samples every further bit at its centre.
- It checks parity and the first stop bit.
- It raises a one-clock pulse when a character is complete.

Clearing the power bit returns both directions to idle and clears every flag.

Top module: `uart_ch`

## Requirements
- R1: Register offsets are fixed: setup 0x0, divider 0x2, status 0x4, receive 0x6, transmit 0x8. After reset, setup and status read 0, the divider reads 16, and the line output is high.
- R2: One bit lasts 2*max(D,4) clocks, where D is the stored divider. A halfword write stores all 16 bits. The raw value reads back unchanged.
- R3: A transmitted frame is laid out as follows. Setup bit 4 and bit 1 pick the data order and length. Bit 0 picks the stop count. The line rests high between frames.
  - A low start bit comes first.
  - The data bits follow. They go least-significant first when setup bit 4 is 1, and most-significant first when it is 0.
  - There are 8 data bits when setup bit 1 is 1, and 7 when it is 0.
  - An optional parity bit follows the data.
  - The frame ends with 1 stop bit when setup bit 0 is 0, or 2 stop bits when it is 1.
- R4: Setup bits 3:2 select parity. 00 means no parity bit. 01 sends a parity bit of 0. 10 is odd (data plus parity hold an odd count of ones). 11 is even.
- R5: Status bit 7 reads 1 while a written character is waiting or being shifted out. The transmit interrupt is a one-clock pulse at the end of the final stop bit of each frame.
- R6: A transmit write that arrives while a character still waits in the holding byte sets status bit 3. That character is dropped.
- R7: The receiver samples each bit at its centre. A low pulse that is gone at mid start bit is ignored. Each character gives a one-clock receive interrupt. A byte read of the receive register returns the character with bits 15:8 zero.
- R8: A halfword receive read returns the character in bits 7:0, the parity error in bit 9 and the framing error in bit 8. A parity mismatch also sets status bit 2. A low first stop bit also sets status bit 1.
- R9: A character that completes while the previous one is unread sets status bit 0 and replaces that character. Reading the receive register marks it read.
- R10: Status bits 3:0 are sticky and clear when the status register is read.
- R11: With setup bit 7 at 0, both shifters reset, all flags clear and the line stays high. Transmit writes are ignored unless bits 7 and 6 are both 1.
- R12: A setup write disables both directions for the next two clocks. A transmit write in the clock right after a setup write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | core clock, also the rate base |
| rst_ni | input | 1 | asynchronous reset, active low |
| bus_sel_i | input | 1 | access strobe, one clock per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_half_i | input | 1 | 1 = halfword access, 0 = byte |
| bus_addr_i | input | 4 | register offset |
| bus_wdata_i | input | 16 | write data |
| bus_rdata_o | output | 16 | read data, valid while a read is strobed |
| rxd_i | input | 1 | serial input line |
| txd_o | output | 1 | serial output line |
| tx_irq_o | output | 1 | end-of-frame pulse |
| rx_irq_o | output | 1 | character-received pulse |

## Verification
The bench sends frames in every order, length, parity and stop setting, and decodes the line at mid-bit. A wrong bit order, a misplaced or wrongly polarised parity bit, or a missing second stop bit therefore shows up as corrupt frames. It programs a divider below the floor; a design without the clamp would produce bits that are too short and fail to decode. The receive tests inject a bad parity bit, a low stop bit, two unread characters in a row and a short start glitch. A design that drops a flag, keeps the old character, or accepts the glitch as a frame returns the wrong status or receive value. Holding-byte overflow, writes during the settle window and power-down clearing are also checked: a design that queues the extra byte or clears nothing would send an unexpected frame or report stale flags.

// File: rtl/uart_ch_pkg.sv
package uart_ch_pkg;
  localparam int DIV_W = 16;
  localparam logic [3:0] OFF_CFG  = 4'h0;
  localparam logic [3:0] OFF_DIV  = 4'h2;
  localparam logic [3:0] OFF_STAT = 4'h4;
  localparam logic [3:0] OFF_RXD  = 4'h6;
  localparam logic [3:0] OFF_TXD  = 4'h8;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_e;

  typedef struct packed {
    logic pwr;
    logic tx_on;
    logic rx_on;
    logic lsb_first;
    par_e par;
    logic len8;
    logic stop2;
  } cfg_t;

  function automatic logic parity_of(logic [7:0] d, logic len8, par_e par);
    logic ones;
    ones = ^{d[7] & len8, d[6:0]};
    case (par)
      PAR_ODD:  return ~ones;
      PAR_EVEN: return ones;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // one tick per half bit
  assign tick_o = run_i && !restart_i && (cnt_q == div_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (tick_o)              cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_ch_pkg::*;
#(
  parameter int FRAME_W = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       len8_i,
  input  logic       lsb_i,
  input  logic       stop2_i,
  input  par_e       par_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       tick_i,
  output logic       txd_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg_q, frame;
  logic [CNT_W-1:0]   left_q, nbits, dlen;
  logic [7:0]         ord;
  logic               half_q;

  always_comb begin
    dlen = len8_i ? CNT_W'(8) : CNT_W'(7);
    for (int i = 0; i < 8; i++) ord[i] = len8_i ? data_i[7-i] : 1'b0;
    if (!len8_i) for (int i = 0; i < 7; i++) ord[i] = data_i[6-i];
    if (lsb_i) ord = data_i;
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (CNT_W'(i) < dlen) frame[i+1] = ord[i];
    if (par_i != PAR_NONE) frame[dlen + 1'b1] = parity_of(data_i, len8_i, par_i);
    nbits = dlen + CNT_W'(par_i != PAR_NONE) + (stop2_i ? CNT_W'(3) : CNT_W'(2));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      left_q  <= '0;
      half_q  <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else if (clr_i) begin
      shreg_q <= '1;
      left_q  <= '0;
      half_q  <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i && !busy_o) begin
        shreg_q <= frame;
        left_q  <= nbits;
        half_q  <= 1'b0;
        busy_o  <= 1'b1;
      end else if (busy_o && tick_i) begin
        half_q <= ~half_q;
        if (half_q) begin
          shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
          left_q  <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end
        end
      end
    end
  end

  assign txd_o = shreg_q[0];
endmodule

// File: rtl/uart_rx_sample.sv
module uart_rx_sample
  import uart_ch_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       len8_i,
  input  logic       lsb_i,
  input  par_e       par_i,
  input  logic       rxd_i,
  input  logic       tick_i,
  output logic       restart_o,
  output logic       run_o,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       pe_o,
  output logic       fe_o
);
  localparam int CNT_W = 4;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

  rx_st_e           st_q;
  logic [CNT_W-1:0] idx_q, dlen, pos;
  logic [7:0]       acc_q;
  logic             half_q, pbit_q, has_par;

  assign has_par   = (par_i != PAR_NONE);
  assign dlen      = len8_i ? CNT_W'(8) : CNT_W'(7);
  assign pos       = lsb_i ? idx_q : (dlen - 1'b1 - idx_q);
  assign restart_o = (st_q == RX_IDLE) && !rxd_i && !clr_i;
  assign run_o     = (st_q != RX_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= RX_IDLE; idx_q <= '0; acc_q <= '0; half_q <= 1'b0; pbit_q <= 1'b0;
      valid_o <= 1'b0; data_o <= '0; pe_o <= 1'b0; fe_o <= 1'b0;
    end else if (clr_i) begin
      st_q <= RX_IDLE; idx_q <= '0; half_q <= 1'b0; valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (st_q)
        RX_IDLE: if (!rxd_i) begin
          st_q   <= RX_START;
          acc_q  <= '0;
          pbit_q <= 1'b0;
        end
        RX_START: if (tick_i) begin
          // mid start bit: high again means glitch
          if (rxd_i) st_q <= RX_IDLE;
          else begin
            st_q   <= RX_BITS;
            idx_q  <= '0;
            half_q <= 1'b0;
          end
        end
        default: if (tick_i) begin
          half_q <= ~half_q;
          if (half_q) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q < dlen) acc_q[pos[2:0]] <= rxd_i;
            else if (has_par && idx_q == dlen) pbit_q <= rxd_i;
            else begin
              valid_o <= 1'b1;
              data_o  <= acc_q;
              fe_o    <= ~rxd_i;
              pe_o    <= has_par && (pbit_q != parity_of(acc_q, len8_i, par_i));
              st_q    <= RX_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_ch.sv
module uart_ch
  import uart_ch_pkg::*;
#(
  parameter int RST_DIV = 16,
  parameter int MIN_DIV = 4,
  parameter int SETTLE  = 2,
  parameter int FRAME_W = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic        bus_half_i,
  input  logic [3:0]  bus_addr_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  input  logic        rxd_i,
  output logic        txd_o,
  output logic        tx_irq_o,
  output logic        rx_irq_o
);
  localparam int SET_W = $clog2(SETTLE + 1);

  cfg_t             cfg_q;
  logic [DIV_W-1:0] div_q, div_eff;
  logic [SET_W-1:0] settle_q;
  logic             wr_cfg, wr_div, wr_tx, rd_stat, rd_rx;
  logic             tx_en, rx_en;

  assign wr_cfg  = bus_sel_i &  bus_we_i & (bus_addr_i == OFF_CFG);
  assign wr_div  = bus_sel_i &  bus_we_i & (bus_addr_i == OFF_DIV);
  assign wr_tx   = bus_sel_i &  bus_we_i & (bus_addr_i == OFF_TXD);
  assign rd_stat = bus_sel_i & ~bus_we_i & (bus_addr_i == OFF_STAT);
  assign rd_rx   = bus_sel_i & ~bus_we_i & (bus_addr_i == OFF_RXD);

  assign tx_en   = cfg_q.pwr & cfg_q.tx_on & (settle_q == '0);
  assign rx_en   = cfg_q.pwr & cfg_q.rx_on & (settle_q == '0);
  assign div_eff = (div_q < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= cfg_t'(8'h00);
      div_q    <= DIV_W'(RST_DIV);
      settle_q <= '0;
    end else begin
      if (wr_cfg) begin
        cfg_q    <= cfg_t'(bus_wdata_i[7:0]);
        settle_q <= SET_W'(SETTLE);
      end else if (settle_q != '0) begin
        settle_q <= settle_q - 1'b1;
      end
      if (wr_div) begin
        if (bus_half_i) div_q <= bus_wdata_i[DIV_W-1:0];
        else            div_q[7:0] <= bus_wdata_i[7:0];
      end
    end
  end

  // transmit path
  logic       tx_busy, tx_tick, tx_done, tx_launch, tx_ovf_ev, pend_q;
  logic [7:0] hold_q;

  assign tx_launch = pend_q & ~tx_busy & tx_en;
  assign tx_ovf_ev = wr_tx & tx_en & pend_q & ~tx_launch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else if (!tx_en) begin
      pend_q <= 1'b0;
    end else if (wr_tx) begin
      if (!(pend_q && !tx_launch)) begin
        hold_q <= bus_wdata_i[7:0];
        pend_q <= 1'b1;
      end
    end else if (tx_launch) begin
      pend_q <= 1'b0;
    end
  end

  uart_baud_tick #(.DIV_W(DIV_W)) u_tx_baud (
    .clk_i, .rst_ni, .run_i(tx_busy), .restart_i(tx_launch),
    .div_i(div_eff), .tick_o(tx_tick)
  );

  uart_tx_shift #(.FRAME_W(FRAME_W)) u_tx (
    .clk_i, .rst_ni, .clr_i(~tx_en),
    .len8_i(cfg_q.len8), .lsb_i(cfg_q.lsb_first), .stop2_i(cfg_q.stop2), .par_i(cfg_q.par),
    .load_i(tx_launch), .data_i(hold_q), .tick_i(tx_tick),
    .txd_o, .busy_o(tx_busy), .done_o(tx_done)
  );

  assign tx_irq_o = tx_done;

  // receive path
  logic [1:0] rxd_s;
  logic       rx_restart, rx_run, rx_tick, rx_valid, rx_pe, rx_fe;
  logic [7:0] rx_char;
  logic [7:0] rx_data_q;
  logic       rx_pe_q, rx_fe_q, rx_full_q, rx_irq_q, ove_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rxd_s <= 2'b11;
    else         rxd_s <= {rxd_s[0], rxd_i};
  end

  uart_baud_tick #(.DIV_W(DIV_W)) u_rx_baud (
    .clk_i, .rst_ni, .run_i(rx_run), .restart_i(rx_restart),
    .div_i(div_eff), .tick_o(rx_tick)
  );

  uart_rx_sample u_rx (
    .clk_i, .rst_ni, .clr_i(~rx_en),
    .len8_i(cfg_q.len8), .lsb_i(cfg_q.lsb_first), .par_i(cfg_q.par),
    .rxd_i(rxd_s[1]), .tick_i(rx_tick),
    .restart_o(rx_restart), .run_o(rx_run), .valid_o(rx_valid),
    .data_o(rx_char), .pe_o(rx_pe), .fe_o(rx_fe)
  );

  assign ove_ev = rx_valid & rx_full_q & ~rd_rx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q <= '0; rx_pe_q <= 1'b0; rx_fe_q <= 1'b0;
      rx_full_q <= 1'b0; rx_irq_q <= 1'b0;
    end else if (!cfg_q.pwr) begin
      rx_data_q <= '0; rx_pe_q <= 1'b0; rx_fe_q <= 1'b0;
      rx_full_q <= 1'b0; rx_irq_q <= 1'b0;
    end else begin
      rx_irq_q <= rx_valid;
      if (rx_valid) begin
        rx_data_q <= rx_char;
        rx_pe_q   <= rx_pe;
        rx_fe_q   <= rx_fe;
        rx_full_q <= 1'b1;
      end else if (rd_rx) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  assign rx_irq_o = rx_irq_q;

  // status: {overflow, parity, framing, overrun}, set wins over read-clear
  logic [3:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         err_q <= '0;
    else if (!cfg_q.pwr) err_q <= '0;
    else err_q <= (rd_stat ? 4'b0000 : err_q) |
                  {tx_ovf_ev, rx_valid & rx_pe, rx_valid & rx_fe, ove_ev};
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      case (bus_addr_i)
        OFF_CFG:  bus_rdata_o = {8'h00, cfg_q};
        OFF_DIV:  bus_rdata_o = div_q;
        OFF_STAT: bus_rdata_o = {8'h00, pend_q | tx_busy, 3'b000, err_q};
        OFF_RXD:  bus_rdata_o = bus_half_i ? {6'b0, rx_pe_q, rx_fe_q, rx_data_q}
                                           : {8'h00, rx_data_q};
        default:  bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_ch_checker.sv
module uart_ch_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       txd_o,
  input logic       tx_irq_o,
  input logic       rx_irq_o,
  input logic       pwr_i,
  input logic [3:0] err_i,
  input logic       full_i,
  input logic       busy_i
);
  a_r11_off_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_i |=> txd_o);
  a_r11_off_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_i |=> (err_i == 4'b0000));
  a_r3_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> txd_o);
  a_r5_tx_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |=> !tx_irq_o);
  a_r5_tx_irq_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> (txd_o && !busy_i));
  a_r7_rx_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o);
  a_r9_rx_irq_marks_unread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> full_i);
endmodule

bind uart_ch uart_ch_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .txd_o(txd_o), .tx_irq_o(tx_irq_o),
  .rx_irq_o(rx_irq_o), .pwr_i(cfg_q.pwr), .err_i(err_q),
  .full_i(rx_full_q), .busy_i(tx_busy)
);

// File: tb/uart_ch_test.sv
module uart_ch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0, half = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rxd = 1'b1;
  logic        txd, tx_irq, rx_irq;

  int n_chk = 0, n_fail = 0;
  int tx_irq_cnt = 0, rx_irq_cnt = 0;
  logic [7:0] cur_cfg = 8'h00;
  int cur_n = 16;
  bit mon_busy = 1'b0;

  typedef struct {
    logic [7:0] d;
    logic [7:0] c;
    int         n;
    string      tag;
  } tx_item_t;
  tx_item_t sb_q[$];

  always #2 clk = ~clk;   // 250 MHz

  uart_ch uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_half_i(half),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rxd_i(rxd), .txd_o(txd), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  always @(negedge clk) begin
    if (tx_irq) tx_irq_cnt++;
    if (rx_irq) rx_irq_cnt++;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // expected frame, bit 0 on the line first
  function automatic int mk_frame(input logic [7:0] d, input logic [7:0] c,
                                  output logic [15:0] f);
    int k, len;
    logic p;
    len = c[1] ? 8 : 7;
    p = 1'b0;
    if (c[3:2] == 2'b10) p = ($countones(d & (c[1] ? 8'hFF : 8'h7F)) % 2) == 0;
    if (c[3:2] == 2'b11) p = ($countones(d & (c[1] ? 8'hFF : 8'h7F)) % 2) == 1;
    f = '1;
    f[0] = 1'b0;
    k = 1;
    for (int j = 0; j < len; j++) begin
      f[k] = c[4] ? d[j] : d[len-1-j];
      k++;
    end
    if (c[3:2] != 2'b00) begin f[k] = p; k++; end
    f[k] = 1'b1; k++;
    if (c[0]) begin f[k] = 1'b1; k++; end
    return k;
  endfunction

  // all tasks start and end on a falling edge
  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d, input logic h);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d; half = h;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic h, output logic [15:0] d);
    sel = 1'b1; we = 1'b0; addr = a; half = h;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic set_cfg(input logic [7:0] c);
    bus_wr(4'h0, {8'h00, c}, 1'b0);
    cur_cfg = c;
    repeat (4) @(negedge clk);
  endtask

  task automatic tx_send(input logic [7:0] d, input string tag);
    tx_item_t it;
    it.d = d; it.c = cur_cfg; it.n = cur_n; it.tag = tag;
    sb_q.push_back(it);
    bus_wr(4'h8, {8'h00, d}, 1'b0);
  endtask

  task automatic wait_tx;
    wait (sb_q.size() == 0);
    wait (!mon_busy);
    @(negedge clk);
    repeat (2 * cur_n + 4) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [15:0] f;
    int nb, len, hp;
    nb  = mk_frame(d, cur_cfg, f);
    len = cur_cfg[1] ? 8 : 7;
    hp  = (cur_cfg[3:2] != 2'b00) ? 1 : 0;
    if (bad_par)  f[1+len]    = ~f[1+len];
    if (bad_stop) f[1+len+hp] = 1'b0;
    for (int b = 0; b < nb; b++) begin
      rxd = f[b];
      repeat (2 * cur_n) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (4 * cur_n) @(negedge clk);
  endtask

  // monitor: decodes the line at mid-bit and compares with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        mon_busy = 1'b1;
        if (sb_q.size() == 0) begin
          check("R11 unexpected frame on line", 1, 0);
          wait (txd === 1'b1);
          @(negedge clk);
        end else begin
          tx_item_t it;
          logic [15:0] f;
          int nb, miss;
          it = sb_q.pop_front();
          nb = mk_frame(it.d, it.c, f);
          miss = 0;
          repeat (it.n) @(negedge clk);
          if (txd !== f[0]) miss++;
          for (int b = 1; b < nb; b++) begin
            repeat (2 * it.n) @(negedge clk);
            if (txd !== f[b]) miss++;
          end
          check($sformatf("%s frame data=0x%0h cfg=0x%0h bit errors", it.tag, it.d, it.c),
                miss, 0);
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic finish_sim;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_sim();
  end

  initial begin
    logic [15:0] r;
    int irq0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(4'h0, 1'b0, r); check("R1 setup after reset", r, 16'h0000);
    bus_rd(4'h2, 1'b1, r); check("R1 divider after reset", r, 16'd16);
    bus_rd(4'h4, 1'b0, r); check("R1 status after reset", r, 16'h0000);
    bus_rd(4'h6, 1'b1, r); check("R1 receive after reset", r, 16'h0000);
    check("R1 line idle high", txd, 1);

    bus_wr(4'h2, 16'd8, 1'b1);
    cur_n = 8;

    // R3 8 data, no parity, 1 stop, LSB first
    set_cfg(8'hF2);
    irq0 = tx_irq_cnt;
    tx_send(8'h55, "R3");
    bus_rd(4'h4, 1'b0, r); check("R5 status busy while sending", r, 16'h0080);
    wait_tx();
    tx_send(8'hC3, "R3");
    wait_tx();
    check("R5 one tx pulse per frame", tx_irq_cnt - irq0, 2);
    bus_rd(4'h4, 1'b0, r); check("R5 status idle after frames", r, 16'h0000);

    // R4 even parity; odd 7-bit MSB first 2 stop; forced zero
    set_cfg(8'hFE); tx_send(8'h07, "R4 even"); wait_tx();
    set_cfg(8'hE9); tx_send(8'h4B, "R4 odd 7-bit msb-first"); wait_tx();
    set_cfg(8'hF7); tx_send(8'hFF, "R4 zero"); tx_send(8'h01, "R4 zero"); wait_tx();

    // R2 divider clamp
    bus_wr(4'h2, 16'd2, 1'b1);
    bus_rd(4'h2, 1'b1, r); check("R2 raw divider readback", r, 16'd2);
    cur_n = 4;
    set_cfg(8'hF2); tx_send(8'h96, "R2 clamped bit time"); wait_tx();
    bus_wr(4'h2, 16'd8, 1'b1);
    cur_n = 8;
    repeat (4) @(negedge clk);

    // R6 holding overflow: A to shifter, B held, C dropped
    tx_send(8'hA1, "R6");
    tx_send(8'hB2, "R6");
    bus_wr(4'h8, 16'h00C3, 1'b0);
    bus_rd(4'h4, 1'b0, r); check("R6 overflow flag with busy", r, 16'h0088);
    wait_tx();
    bus_rd(4'h4, 1'b0, r); check("R10 status cleared by read", r, 16'h0000);

    // R12 write right after setup write is ignored
    bus_wr(4'h0, 16'h00F2, 1'b0);
    bus_wr(4'h8, 16'h005A, 1'b0);
    repeat (4) @(negedge clk);
    bus_rd(4'h4, 1'b0, r); check("R12 tx write in settle window ignored", r, 16'h0000);
    repeat (300) @(negedge clk);

    // R11 transmit disabled
    set_cfg(8'hB2);
    irq0 = tx_irq_cnt;
    bus_wr(4'h8, 16'h0033, 1'b0);
    bus_rd(4'h4, 1'b0, r); check("R11 tx write ignored while disabled", r, 16'h0000);
    repeat (300) @(negedge clk);
    check("R11 no tx pulse while disabled", tx_irq_cnt - irq0, 0);

    // R7 receive 8N1
    set_cfg(8'hF2);
    irq0 = rx_irq_cnt;
    rx_frame(8'hA5, 0, 0);
    check("R7 rx pulse", rx_irq_cnt - irq0, 1);
    bus_rd(4'h6, 1'b1, r); check("R8 halfword receive clean", r, 16'h00A5);

    // R7 7-bit odd MSB first, byte view
    set_cfg(8'hE9);
    rx_frame(8'h5A, 0, 0);
    bus_rd(4'h6, 1'b0, r); check("R7 byte receive 7-bit msb-first", r, 16'h005A);
    bus_rd(4'h4, 1'b0, r); check("R7 no error flags", r, 16'h0000);

    // R8 parity error with even parity
    set_cfg(8'hFE);
    rx_frame(8'h3C, 1, 0);
    bus_rd(4'h4, 1'b0, r); check("R8 status parity flag", r, 16'h0004);
    bus_rd(4'h6, 1'b1, r); check("R8 halfword parity flag", r, 16'h023C);

    // R8 framing error
    set_cfg(8'hF2);
    rx_frame(8'h81, 0, 1);
    bus_rd(4'h6, 1'b1, r); check("R8 halfword framing flag", r, 16'h0181);
    bus_rd(4'h4, 1'b0, r); check("R8 status framing flag", r, 16'h0002);

    // R9 overrun
    irq0 = rx_irq_cnt;
    rx_frame(8'h11, 0, 0);
    rx_frame(8'h22, 0, 0);
    check("R9 two rx pulses", rx_irq_cnt - irq0, 2);
    bus_rd(4'h4, 1'b0, r); check("R9 overrun flag", r, 16'h0001);
    bus_rd(4'h6, 1'b0, r); check("R9 newest character kept", r, 16'h0022);
    bus_rd(4'h4, 1'b0, r); check("R10 overrun cleared by read", r, 16'h0000);
    rx_frame(8'h33, 0, 0);
    bus_rd(4'h4, 1'b0, r); check("R9 read marks character taken", r, 16'h0000);
    bus_rd(4'h6, 1'b0, r);

    // R7 start glitch rejected
    irq0 = rx_irq_cnt;
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (80) @(negedge clk);
    check("R7 glitch gives no rx pulse", rx_irq_cnt - irq0, 0);
    bus_rd(4'h4, 1'b0, r); check("R7 glitch sets no flag", r, 16'h0000);

    // R11 power off clears flags
    rx_frame(8'h44, 0, 0);
    rx_frame(8'h55, 0, 0);
    bus_wr(4'h0, 16'h0000, 1'b0);
    cur_cfg = 8'h00;
    repeat (2) @(negedge clk);
    bus_rd(4'h4, 1'b0, r); check("R11 power off clears status", r, 16'h0000);
    bus_rd(4'h6, 1'b1, r); check("R11 power off clears receive", r, 16'h0000);
    check("R11 line high when off", txd, 1);

    check("R3 every queued frame seen", sb_q.size(), 0);
    finish_sim();
  end
endmodule